// File: doc/BRIEF.md
# Debug Data Transfer Channel

This block carries 32-bit words in both directions between a halted processor core and an external scan-based debugger. The core writes words into an outbound register that the debugger collects. The debugger deposits words into an inbound register that the core reads. Each register has an occupancy flag. Two more flags help the debugger drive the core: an instruction-complete flag and a sticky abort flag.

The debugger reaches the block through TAP data-register strobes: capture, shift and update. An instruction-select input chooses between internal test (INTEST) and external test (EXTEST). At capture, a 33-bit chain is loaded with the outbound word and a status bit. A gating flag is captured at the same time, and it decides whether the following update may overwrite the inbound register. A mode input sets which flag does the gating. In communication mode it is the inbound-empty flag. In execution mode it is the instruction-complete flag.

Top module: `dbg_dtr_channel`

## Requirements
- R1: After reset: outbound-full is 0, inbound-empty is 1, instruction-complete is 1, sticky abort is 0, both data registers are 0, and tdo is 0.
- R2: A core write stores core_wr_data and sets outbound-full. If an INTEST capture happens in the same cycle, the capture loads the previous word and outbound-full ends set.
- R3: Capture loads the chain with the outbound word in bits 32:1 and the current outbound-full flag in bit 0. This happens under both INTEST (intest_sel=1) and EXTEST (intest_sel=0). Only an INTEST capture clears outbound-full.
- R4: During shift, tdo shows chain bit 0, the chain moves one place toward bit 0, and tdi enters bit 32. After 33 shifts, bits 32:1 hold the word presented to the update.
- R5: An accepted update loads the inbound register from chain bits 32:1 and clears inbound-empty. A core read sets inbound-empty. When both happen in the same cycle, the debugger word is kept and inbound-empty ends 0.
- R6: In communication mode (exec_mode=0), an update is accepted only if inbound-empty was 1 at the preceding capture. Otherwise the inbound register is left unchanged.
- R7: In communication mode, instr_compl reads 1 whatever its stored state.
- R8: In execution mode (exec_mode=1), instr_issue clears instruction-complete and instr_done sets it. If both arrive in the same cycle, the flag ends 0.
- R9: In execution mode, an update is accepted only if instruction-complete was 1 at the preceding capture.
- R10: In execution mode, precise_abort sets the sticky abort flag. The flag then stays set until reset.
- R11: Changing exec_mode in either direction alters no register or stored flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| intest_sel | input | 1 | 1 = INTEST selected, 0 = EXTEST |
| tdi | input | 1 | Serial data in |
| exec_mode | input | 1 | 0 = communication, 1 = instruction execution |
| core_wr_en | input | 1 | Core writes the outbound register |
| core_wr_data | input | 32 | Core write word |
| core_rd_en | input | 1 | Core reads the inbound register |
| instr_issue | input | 1 | Instruction issued to the core |
| instr_done | input | 1 | Issued instruction has completed |
| precise_abort | input | 1 | Precise data abort event |
| tdo | output | 1 | Serial data out |
| rd_data | output | 32 | Inbound register contents |
| rd_empty | output | 1 | Inbound-empty flag |
| wr_full | output | 1 | Outbound-full flag |
| instr_compl | output | 1 | Instruction-complete flag as seen |
| sticky_abort | output | 1 | Sticky abort flag |

## Verification
The bench targets overwrite protection in both modes. A design that gated on the live flag instead of the captured one, or on the wrong flag for the mode, would replace an inbound word that the core has not yet consumed. It also checks that an EXTEST capture leaves outbound-full set; a design that cleared it would lose the only notice that a word is waiting. The same-cycle collisions are driven deliberately: a core read against an update, and a core write against an INTEST capture. Getting these wrong would leave the flags claiming empty with live data present. Mode toggles with a pending instruction show whether the complete flag is forced only at the output or wrongly in the stored state.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  typedef enum logic {
    MODE_COMM = 1'b0,
    MODE_EXEC = 1'b1
  } dtr_mode_e;
endpackage

// File: rtl/dtr_scan_chain.sv
module dtr_scan_chain #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_status,
  input  logic              cap_gate,
  output logic              tdo,
  output logic [DATA_W-1:0] upd_word,
  output logic              upd_accept
);
  localparam int unsigned CHAIN_W = DATA_W + 1;

  logic [CHAIN_W-1:0] chain_q, chain_d;
  logic               gate_q, gate_d;

  always_comb begin
    chain_d = chain_q;
    gate_d  = gate_q;
    if (capture) begin
      chain_d = {cap_data, cap_status};
      gate_d  = cap_gate;
    end else if (shift) begin
      chain_d = {tdi, chain_q[CHAIN_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      gate_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      gate_q  <= gate_d;
    end
  end

  assign tdo        = chain_q[0];
  assign upd_word   = chain_q[CHAIN_W-1:1];
  assign upd_accept = update & gate_q;
endmodule

// File: rtl/dtr_flags.sv
module dtr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic exec_en,
  input  logic core_wr_en,
  input  logic core_rd_en,
  input  logic cap_intest,
  input  logic upd_accept,
  input  logic instr_issue,
  input  logic instr_done,
  input  logic precise_abort,
  output logic wr_full_q,
  output logic rd_empty_q,
  output logic cmpl_q,
  output logic abort_q
);
  logic wr_full_d, rd_empty_d, cmpl_d, abort_d;

  always_comb begin
    wr_full_d = wr_full_q;
    if (cap_intest) wr_full_d = 1'b0;
    if (core_wr_en) wr_full_d = 1'b1;

    rd_empty_d = rd_empty_q;
    if (core_rd_en) rd_empty_d = 1'b1;
    if (upd_accept) rd_empty_d = 1'b0;

    cmpl_d = cmpl_q;
    if (exec_en) begin
      if (instr_done)  cmpl_d = 1'b1;
      if (instr_issue) cmpl_d = 1'b0;
    end

    abort_d = abort_q;
    if (exec_en && precise_abort) abort_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_full_q  <= 1'b0;
      rd_empty_q <= 1'b1;
      cmpl_q     <= 1'b1;
      abort_q    <= 1'b0;
    end else begin
      wr_full_q  <= wr_full_d;
      rd_empty_q <= rd_empty_d;
      cmpl_q     <= cmpl_d;
      abort_q    <= abort_d;
    end
  end
endmodule

// File: rtl/dtr_data_regs.sv
module dtr_data_regs #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] upd_word,
  output logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] in_q
);
  logic [DATA_W-1:0] out_d, in_d;

  always_comb begin
    out_d = wr_en  ? wr_word  : out_q;
    in_d  = upd_en ? upd_word : in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      out_q <= out_d;
      in_q  <= in_d;
    end
  end
endmodule

// File: rtl/dbg_dtr_channel.sv
module dbg_dtr_channel
  import dtr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              intest_sel,
  input  logic              tdi,
  input  logic              exec_mode,
  input  logic              core_wr_en,
  input  logic [DATA_W-1:0] core_wr_data,
  input  logic              core_rd_en,
  input  logic              instr_issue,
  input  logic              instr_done,
  input  logic              precise_abort,
  output logic              tdo,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              wr_full,
  output logic              instr_compl,
  output logic              sticky_abort
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dtr_mode_e         mode;
  logic [DATA_W-1:0] out_word, upd_word;
  logic              upd_accept, cmpl_q, cap_gate;

  assign mode = dtr_mode_e'(exec_mode);

  assign cap_gate = (mode == MODE_EXEC) ? cmpl_q : rd_empty;

  dtr_scan_chain #(.DATA_W(DATA_W)) u_chain (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .capture    (capture_dr),
    .shift      (shift_dr),
    .update     (update_dr),
    .tdi        (tdi),
    .cap_data   (out_word),
    .cap_status (wr_full),
    .cap_gate   (cap_gate),
    .tdo        (tdo),
    .upd_word   (upd_word),
    .upd_accept (upd_accept)
  );

  dtr_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .exec_en       (mode == MODE_EXEC),
    .core_wr_en    (core_wr_en),
    .core_rd_en    (core_rd_en),
    .cap_intest    (capture_dr & intest_sel),
    .upd_accept    (upd_accept),
    .instr_issue   (instr_issue),
    .instr_done    (instr_done),
    .precise_abort (precise_abort),
    .wr_full_q     (wr_full),
    .rd_empty_q    (rd_empty),
    .cmpl_q        (cmpl_q),
    .abort_q       (sticky_abort)
  );

  dtr_data_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (core_wr_en),
    .wr_word  (core_wr_data),
    .upd_en   (upd_accept),
    .upd_word (upd_word),
    .out_q    (out_word),
    .in_q     (rd_data)
  );

  assign instr_compl = (mode == MODE_EXEC) ? cmpl_q : 1'b1;
endmodule

// File: rtl/dtr_channel_checks.sv
module dtr_channel_checks #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec_mode,
  input logic              core_wr_en,
  input logic              core_rd_en,
  input logic              capture_dr,
  input logic              intest_sel,
  input logic              update_dr,
  input logic              instr_issue,
  input logic              precise_abort,
  input logic              wr_full,
  input logic              rd_empty,
  input logic              instr_compl,
  input logic              sticky_abort,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] upd_word,
  input logic              upd_accept
);
  assert_core_write_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_en |=> wr_full);

  assert_extest_keeps_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_dr && !intest_sel && wr_full) |=> wr_full);

  assert_update_loads_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_accept |=> (rd_data == $past(upd_word)) && !rd_empty);

  assert_core_read_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd_en && !upd_accept) |=> rd_empty);

  assert_comm_blocked_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (update_dr && !upd_accept && !exec_mode) |=> $stable(rd_data));

  assert_comm_reads_complete_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_mode |-> instr_compl);

  assert_issue_clears_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_mode && instr_issue && $stable(exec_mode)) |=> (!exec_mode || !instr_compl));

  assert_exec_blocked_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (update_dr && !upd_accept && exec_mode) |=> $stable(rd_data));

  assert_abort_sets_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_mode && precise_abort) |=> sticky_abort);

  assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_abort |=> sticky_abort);
endmodule

bind dbg_dtr_channel dtr_channel_checks #(.DATA_W(DATA_W)) u_checks (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .exec_mode     (exec_mode),
  .core_wr_en    (core_wr_en),
  .core_rd_en    (core_rd_en),
  .capture_dr    (capture_dr),
  .intest_sel    (intest_sel),
  .update_dr     (update_dr),
  .instr_issue   (instr_issue),
  .precise_abort (precise_abort),
  .wr_full       (wr_full),
  .rd_empty      (rd_empty),
  .instr_compl   (instr_compl),
  .sticky_abort  (sticky_abort),
  .rd_data       (rd_data),
  .upd_word      (upd_word),
  .upd_accept    (upd_accept)
);

// File: tb/test_dbg_dtr_channel.sv
module test_dbg_dtr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic        intest_sel = 1'b0, tdi = 1'b0, exec_mode = 1'b0;
  logic        core_wr_en = 1'b0, core_rd_en = 1'b0;
  logic [31:0] core_wr_data = '0;
  logic        instr_issue = 1'b0, instr_done = 1'b0, precise_abort = 1'b0;
  logic        tdo, rd_empty, wr_full, instr_compl, sticky_abort;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [32:0] exp_q[$];
  logic [32:0] scan_act;
  event        scan_done;

  always #5 clk = ~clk;

  dbg_dtr_channel i_dbg_dtr_channel (
    .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .intest_sel(intest_sel), .tdi(tdi), .exec_mode(exec_mode),
    .core_wr_en(core_wr_en), .core_wr_data(core_wr_data), .core_rd_en(core_rd_en),
    .instr_issue(instr_issue), .instr_done(instr_done), .precise_abort(precise_abort),
    .tdo(tdo), .rd_data(rd_data), .rd_empty(rd_empty), .wr_full(wr_full),
    .instr_compl(instr_compl), .sticky_abort(sticky_abort)
  );

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compares each collected chain image against the scoreboard (R3, R4)
  initial begin
    forever begin
      @(scan_done);
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 actual=%h expected=<none queued>", scan_act);
      end else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        if (scan_act !== e) begin
          errors++;
          $display("FAIL R3/R4 scan actual=%h expected=%h", scan_act, e);
        end
      end
    end
  end

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic core_write(input logic [31:0] w);
    core_wr_data = w;
    core_wr_en = 1'b1;
    @(negedge clk);
    core_wr_en = 1'b0;
    @(negedge clk);
  endtask

  // Driver: capture, 33 shifts, update; expected chain image goes to the queue
  task automatic scan(input logic sel, input logic [31:0] din, input logic [32:0] exp,
                      input logic rd_at_upd, input logic wr_at_cap, input logic [31:0] wword);
    logic [32:0] v;
    logic [32:0] got;
    v = {din, 1'b0};
    exp_q.push_back(exp);
    intest_sel = sel;
    capture_dr = 1'b1;
    if (wr_at_cap) begin
      core_wr_data = wword;
      core_wr_en = 1'b1;
    end
    @(negedge clk);
    capture_dr = 1'b0;
    core_wr_en = 1'b0;
    shift_dr = 1'b1;
    for (int i = 0; i < 33; i++) begin
      tdi = v[i];
      got[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 1'b0;
    scan_act = got;
    ->scan_done;
    update_dr = 1'b1;
    if (rd_at_upd) core_rd_en = 1'b1;
    @(negedge clk);
    update_dr = 1'b0;
    core_rd_en = 1'b0;
    @(negedge clk);
  endtask

  localparam logic [31:0] W1 = 32'hA5A5_0F0F, W2 = 32'h7E57_C0DE;
  localparam logic [31:0] D1 = 32'h1234_5678, D2 = 32'hDEAD_BEEF, D3 = 32'h0BAD_F00D;
  localparam logic [31:0] D4 = 32'hCAFE_0001, D5 = 32'h5555_AAAA, D6 = 32'h8000_0001;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 wr_full", {32'd0, wr_full}, 33'd0);
    chk("R1 rd_empty", {32'd0, rd_empty}, 33'd1);
    chk("R1 instr_compl", {32'd0, instr_compl}, 33'd1);
    chk("R1 sticky_abort", {32'd0, sticky_abort}, 33'd0);
    chk("R1 rd_data", {1'b0, rd_data}, 33'd0);
    chk("R1 tdo", {32'd0, tdo}, 33'd0);

    // R2 core write
    core_write(W1);
    chk("R2 wr_full set", {32'd0, wr_full}, 33'd1);

    // R3 EXTEST capture keeps full; R6 empty inbound accepts update
    scan(1'b0, D1, {W1, 1'b1}, 1'b0, 1'b0, '0);
    chk("R3 extest keeps full", {32'd0, wr_full}, 33'd1);
    chk("R6 update accepted", {1'b0, rd_data}, {1'b0, D1});
    chk("R5 empty cleared", {32'd0, rd_empty}, 33'd0);

    // R3 INTEST clears full; R6 full inbound blocks update
    scan(1'b1, D2, {W1, 1'b1}, 1'b0, 1'b0, '0);
    chk("R3 intest clears full", {32'd0, wr_full}, 33'd0);
    chk("R6 update blocked", {1'b0, rd_data}, {1'b0, D1});

    // R5 core read sets empty
    pulse(core_rd_en);
    chk("R5 core read empties", {32'd0, rd_empty}, 33'd1);
    scan(1'b1, D3, {W1, 1'b0}, 1'b0, 1'b0, '0);
    chk("R4 shifted word lands", {1'b0, rd_data}, {1'b0, D3});
    chk("R7 comm complete", {32'd0, instr_compl}, 33'd1);

    // R11 switching into execution mode changes nothing
    exec_mode = 1'b1;
    @(negedge clk);
    chk("R11 wr_full", {32'd0, wr_full}, 33'd0);
    chk("R11 rd_empty", {32'd0, rd_empty}, 33'd0);
    chk("R11 rd_data", {1'b0, rd_data}, {1'b0, D3});
    chk("R11 instr_compl", {32'd0, instr_compl}, 33'd1);

    // R8, R9 execution gating
    pulse(instr_issue);
    chk("R8 issue clears", {32'd0, instr_compl}, 33'd0);
    pulse(core_rd_en);
    scan(1'b0, D4, {W1, 1'b0}, 1'b0, 1'b0, '0);
    chk("R9 busy blocks update", {1'b0, rd_data}, {1'b0, D3});
    chk("R9 empty untouched", {32'd0, rd_empty}, 33'd1);
    pulse(instr_done);
    chk("R8 done sets", {32'd0, instr_compl}, 33'd1);
    scan(1'b0, D5, {W1, 1'b0}, 1'b0, 1'b0, '0);
    chk("R9 complete allows update", {1'b0, rd_data}, {1'b0, D5});

    // R10 sticky abort
    pulse(precise_abort);
    repeat (3) @(negedge clk);
    chk("R10 sticky set and held", {32'd0, sticky_abort}, 33'd1);

    // R7 / R11 mode toggles with a pending instruction
    pulse(instr_issue);
    exec_mode = 1'b0;
    @(negedge clk);
    chk("R7 forced complete in comm", {32'd0, instr_compl}, 33'd1);
    exec_mode = 1'b1;
    @(negedge clk);
    chk("R11 stored complete kept", {32'd0, instr_compl}, 33'd0);
    chk("R10 sticky survives toggles", {32'd0, sticky_abort}, 33'd1);
    pulse(instr_done);
    exec_mode = 1'b0;
    @(negedge clk);

    // R5 simultaneous core read and update
    pulse(core_rd_en);
    scan(1'b1, D6, {W1, 1'b0}, 1'b1, 1'b0, '0);
    chk("R5 collision keeps word", {1'b0, rd_data}, {1'b0, D6});
    chk("R5 collision empty cleared", {32'd0, rd_empty}, 33'd0);

    // R2 simultaneous core write and INTEST capture
    scan(1'b1, D1, {W1, 1'b0}, 1'b0, 1'b1, W2);
    chk("R2 write beats intest clear", {32'd0, wr_full}, 33'd1);
    scan(1'b0, D2, {W2, 1'b1}, 1'b0, 1'b0, '0);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R4 actual=%0d expected=0 pending scans", exp_q.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule